// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Interrupt

This block is a watchdog peripheral with a small 8-bit register interface. Once it is armed, it counts pulses of a slow timer tick. If software does not restart it within a programmable time-out, the block raises a sticky system reset request. Software restarts the count by writing a fixed key byte to a dedicated clear location. A wrong byte written there counts as a fault.

An optional window mode places a closed interval after every restart. A correct clear that arrives inside this interval is also treated as a fault. After the interval the window opens, and the time-out is measured from the moment it opens. A separate early-warning offset sets a flag part way into the counted period. That flag drives an interrupt output through an enable bit.

An always-on bit arms the watchdog and freezes its control and configuration until the next system reset. Time-out, window and early-warning lengths all use one 4-bit code, n, that selects 8·2^n ticks.

Top module: `wdw_top`

## Requirements
- R1: After reset, the registers read as follows: control (0x0) reads 0x00, configuration (0x1) reads 0xBB, early-warning control (0x2) reads 0x0B, interrupt enable (0x4/0x5), flag (0x6) and status (0x7) read 0x00, and `rst_req_o` and `irq_o` are low.
- R2: Control is written at offset 0x0, and only bits 1 (enable), 2 (window enable) and 7 (always-on) are stored. Early-warning control at 0x2 stores only bits 3:0. Configuration at 0x1 stores the whole byte: time-out code in bits 3:0, window code in bits 7:4.
- R3: The block is active when enable or always-on is set. While active, only cycles with `tick_i` high are counted. `rst_req_o` rises after the clock edge that carries the 8·2^n-th counted tick of the open period, where n is the time-out code. Codes above 0xB act as 0xB. `rst_req_o` stays high until `rst_ni`.
- R4: While active and outside the closed window, writing 0xA5 to offset 0x8 restarts the count. If that write falls on the same edge as the tick that would time out, the restart wins and no reset request is raised.
- R5: While active, writing any other byte to 0x8 raises `rst_req_o` after that edge. While the block is inactive, writes to 0x8 have no effect.
- R6: With window enable set, each enable or restart begins a closed phase of 8·2^w ticks, where w is the window code. A write to 0x8 on any edge up to and including the one that ends that phase raises `rst_req_o`. A correct key written after the phase restarts the count, and a new closed phase follows before the time-out counting begins.
- R7: The early-warning flag (bit 0 at 0x6) is set on the edge carrying the 8·2^e-th counted tick of the open period, where e is the early-warning code. Writing 1 to bit 0 at 0x6 clears the flag. If a set and a clear fall on the same edge, the set wins.
- R8: Writing 1 to bit 0 at 0x5 sets the interrupt enable, and writing 1 to bit 0 at 0x4 clears it. Both offsets read the enable in bit 0. `irq_o` is high exactly when both the flag and the enable are set.
- R9: Once always-on is set, writes to 0x0 and 0x1 are ignored until `rst_ni`, and the watchdog counts even with the enable bit clear.
- R10: Status bit 7 reads 1 for SYNC_LAT cycles after a write to 0x0, 0x1 or 0x8, and reads 0 otherwise.
- R11: Reads of offset 0x3, offset 0x8 and unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer tick enable, one count per high cycle |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read otherwise |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| rst_req_o | output | 1 | Sticky system reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with its default parameters: a base of 8 ticks, a top code of 0xB and a two-cycle busy indication. It holds `tick_i` high for most of the run, so the short codes 0 to 3 time out within tens of cycles. This allows randomized trials over time-out, window and early-warning codes, with clears at arbitrary points, including the exact phase-boundary edges. One directed run with code 0xF covers the full 16384-tick ceiling and the clamping of codes above 0xB. A further run with `tick_i` low shows that counting stalls without ticks.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  localparam logic [3:0] A_CTRL    = 4'h0;
  localparam logic [3:0] A_CFG     = 4'h1;
  localparam logic [3:0] A_EWC     = 4'h2;
  localparam logic [3:0] A_IEN_CLR = 4'h4;
  localparam logic [3:0] A_IEN_SET = 4'h5;
  localparam logic [3:0] A_FLAG    = 4'h6;
  localparam logic [3:0] A_STAT    = 4'h7;
  localparam logic [3:0] A_KICK    = 4'h8;

  localparam logic [7:0] KICK_KEY = 8'hA5;

  localparam int EN_BIT   = 1;
  localparam int WEN_BIT  = 2;
  localparam int AON_BIT  = 7;
  localparam int BUSY_BIT = 7;

  typedef struct packed {
    logic [3:0] win;
    logic [3:0] per;
  } cfg_t;

  localparam cfg_t       CFG_RST = 8'hBB;
  localparam logic [3:0] EWC_RST = 4'hB;

  // ticks selected by a period code, clamped at max_code
  function automatic int unsigned code_span(input logic [3:0] code, input int base_log2,
                                            input int max_code);
    int c;
    c = (int'(code) > max_code) ? max_code : int'(code);
    return 32'd1 << (base_log2 + c);
  endfunction

endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter int SYNC_LAT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       ew_hit_i,
  output logic       en_o,
  output logic       wen_o,
  output logic       aon_o,
  output cfg_t       cfg_o,
  output logic [3:0] ewc_o,
  output logic       ie_o,
  output logic       flag_o,
  output logic       kick_wr_o,
  output logic       key_ok_o,
  output logic       busy_o
);

  localparam int BW = $clog2(SYNC_LAT + 1);

  logic          wr;
  logic          en_q, wen_q, aon_q, ie_q, flag_q;
  cfg_t          cfg_q;
  logic [3:0]    ewc_q;
  logic [BW-1:0] busy_q;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      wen_q  <= 1'b0;
      aon_q  <= 1'b0;
      cfg_q  <= CFG_RST;
      ewc_q  <= EWC_RST;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      busy_q <= '0;
    end else begin
      if (wr && addr_i == A_CTRL && !aon_q) begin
        en_q  <= wdata_i[EN_BIT];
        wen_q <= wdata_i[WEN_BIT];
        aon_q <= wdata_i[AON_BIT];
      end
      if (wr && addr_i == A_CFG && !aon_q) cfg_q <= cfg_t'(wdata_i);
      if (wr && addr_i == A_EWC) ewc_q <= wdata_i[3:0];
      if (wr && addr_i == A_IEN_SET && wdata_i[0]) ie_q <= 1'b1;
      else if (wr && addr_i == A_IEN_CLR && wdata_i[0]) ie_q <= 1'b0;
      if (ew_hit_i) flag_q <= 1'b1;
      else if (wr && addr_i == A_FLAG && wdata_i[0]) flag_q <= 1'b0;
      if (wr && (addr_i == A_CTRL || addr_i == A_CFG || addr_i == A_KICK))
        busy_q <= BW'(SYNC_LAT);
      else if (busy_q != '0)
        busy_q <= busy_q - 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[EN_BIT]  = en_q;
        rdata_o[WEN_BIT] = wen_q;
        rdata_o[AON_BIT] = aon_q;
      end
      A_CFG:                rdata_o = cfg_q;
      A_EWC:                rdata_o[3:0] = ewc_q;
      A_IEN_CLR, A_IEN_SET: rdata_o[0] = ie_q;
      A_FLAG:               rdata_o[0] = flag_q;
      A_STAT:               rdata_o[BUSY_BIT] = busy_o;
      default:              rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign wen_o     = wen_q;
  assign aon_o     = aon_q;
  assign cfg_o     = cfg_q;
  assign ewc_o     = ewc_q;
  assign ie_o      = ie_q;
  assign flag_o    = flag_q;
  assign kick_wr_o = wr && addr_i == A_KICK;
  assign key_ok_o  = wdata_i == KICK_KEY;
  assign busy_o    = busy_q != '0;

endmodule

// File: rtl/wdw_core.sv
module wdw_core
  import wdw_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int MAX_CODE  = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       active_i,
  input  logic       wen_i,
  input  cfg_t       cfg_i,
  input  logic [3:0] ewc_i,
  input  logic       kick_wr_i,
  input  logic       key_ok_i,
  output logic       rst_req_o,
  output logic       ew_hit_o,
  output logic       closed_o
);

  localparam int CNT_W = BASE_LOG2 + MAX_CODE + 1;

  logic [CNT_W-1:0] cnt_q, nxt, per_len, win_len, ew_len;
  logic             open_q, rst_q, closed, kick, fault, run;

  assign per_len = CNT_W'(code_span(cfg_i.per, BASE_LOG2, MAX_CODE));
  assign win_len = CNT_W'(code_span(cfg_i.win, BASE_LOG2, MAX_CODE));
  assign ew_len  = CNT_W'(code_span(ewc_i, BASE_LOG2, MAX_CODE));

  assign nxt    = cnt_q + CNT_W'(1);
  assign closed = wen_i & ~open_q;
  assign kick   = active_i & kick_wr_i & key_ok_i & ~closed;
  assign fault  = active_i & kick_wr_i & (~key_ok_i | closed);
  // a counted tick of the open period that no restart overrides
  assign run    = active_i & tick_i & ~closed & ~kick & ~rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (!active_i || kick) begin
        cnt_q  <= '0;
        open_q <= 1'b0;
      end else if (tick_i && !rst_q) begin
        if (closed && nxt >= win_len) begin
          cnt_q  <= '0;
          open_q <= 1'b1;
        end else begin
          cnt_q <= nxt;
        end
      end
      if (fault || (run && nxt >= per_len)) rst_q <= 1'b1;
    end
  end

  assign rst_req_o = rst_q;
  assign ew_hit_o  = run && nxt == ew_len;
  assign closed_o  = closed;

endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int MAX_CODE  = 11,
  parameter int SYNC_LAT  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rst_req_o,
  output logic       irq_o
);

  logic       en, wen, aon, active, ie, flag, kick_wr, key_ok, busy, ew_hit, win_closed;
  cfg_t       cfg_q;
  logic [3:0] ewc;

  wdw_regs #(.SYNC_LAT(SYNC_LAT)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ew_hit_i (ew_hit),
    .en_o     (en),
    .wen_o    (wen),
    .aon_o    (aon),
    .cfg_o    (cfg_q),
    .ewc_o    (ewc),
    .ie_o     (ie),
    .flag_o   (flag),
    .kick_wr_o(kick_wr),
    .key_ok_o (key_ok),
    .busy_o   (busy)
  );

  assign active = en | aon;

  wdw_core #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) i_core (
    .clk_i, .rst_ni, .tick_i,
    .active_i (active),
    .wen_i    (wen),
    .cfg_i    (cfg_q),
    .ewc_i    (ewc),
    .kick_wr_i(kick_wr),
    .key_ok_i (key_ok),
    .rst_req_o,
    .ew_hit_o (ew_hit),
    .closed_o (win_closed)
  );

  assign irq_o = flag & ie;

endmodule

// File: rtl/wdw_checker.sv
module wdw_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [3:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       rst_req_o,
  input logic       irq_o,
  input logic       active,
  input logic       closed,
  input logic       busy,
  input logic       aon,
  input logic [7:0] cfg
);

  logic kick_wr;
  assign kick_wr = req_i && we_i && addr_i == 4'h8;

  p_rst_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  p_good_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_wr && wdata_i == 8'hA5 && active && !closed && !rst_req_o |=> !rst_req_o);

  p_bad_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_wr && wdata_i != 8'hA5 && active |=> rst_req_o);

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active && !rst_req_o |=> !rst_req_o);

  p_early_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_wr && active && closed |=> rst_req_o);

  p_ie_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == 4'h4 && wdata_i[0] |=> !irq_o);

  p_aon_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aon |=> aon && $stable(cfg));

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == 4'h0 |=> busy);

endmodule

bind wdw_top wdw_checker i_wdw_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rst_req_o(rst_req_o),
  .irq_o    (irq_o),
  .active   (active),
  .closed   (win_closed),
  .busy     (busy),
  .aon      (aon),
  .cfg      (cfg_q)
);

// File: tb/test_wdw_top.sv
module test_wdw_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rst_req_o, irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  wdw_top i_wdw_top (.*);

  function automatic int span(input int code);
    return 8 << ((code > 11) ? 11 : code);
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; tick_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    do_reset();

    // R1 reset values
    rd(4'h0, v); chk("R1", v, 8'h00, "ctrl");
    rd(4'h1, v); chk("R1", v, 8'hBB, "cfg");
    rd(4'h2, v); chk("R1", v, 8'h0B, "ewc");
    rd(4'h4, v); chk("R1", v, 8'h00, "ien");
    rd(4'h6, v); chk("R1", v, 8'h00, "flag");
    rd(4'h7, v); chk("R1", v, 8'h00, "status");
    chk("R1", rst_req_o, 0, "rst_req");
    chk("R1", irq_o, 0, "irq");

    // R5 clear ignored while inactive; R11 holes read zero
    wr(4'h8, 8'h00); idle(3);
    chk("R5", rst_req_o, 0, "inactive bad key");
    rd(4'h3, v); chk("R11", v, 8'h00, "reserved 0x3");
    rd(4'h8, v); chk("R11", v, 8'h00, "clear reads 0");
    rd(4'hC, v); chk("R11", v, 8'h00, "unmapped");

    // R2 write masks
    wr(4'h2, 8'hFF); rd(4'h2, v); chk("R2", v, 8'h0F, "ewc mask");
    wr(4'h1, 8'h5A); rd(4'h1, v); chk("R2", v, 8'h5A, "cfg full byte");
    wr(4'h0, 8'h7F); rd(4'h0, v); chk("R2", v, 8'h06, "ctrl mask");

    // R3 basic time-out, stickiness
    do_reset();
    wr(4'h1, 8'h00); wr(4'h0, 8'h02);
    idle(7); chk("R3", rst_req_o, 0, "before 8 ticks");
    idle(1); chk("R3", rst_req_o, 1, "at 8 ticks");
    idle(5); chk("R3", rst_req_o, 1, "sticky");

    // R3 counting stalls without ticks
    do_reset();
    wr(4'h1, 8'h00); tick_i = 1'b0; wr(4'h0, 8'h02);
    idle(50); chk("R3", rst_req_o, 0, "no ticks");
    tick_i = 1'b1;
    idle(7); chk("R3", rst_req_o, 0, "7 ticks");
    idle(1); chk("R3", rst_req_o, 1, "8 ticks");

    // R5 wrong key while active
    do_reset();
    wr(4'h0, 8'h02); idle(3); wr(4'h8, 8'h5A);
    chk("R5", rst_req_o, 1, "bad key");

    // R4 restart mid-period
    do_reset();
    wr(4'h1, 8'h01); wr(4'h0, 8'h02); idle(9); wr(4'h8, 8'hA5);
    chk("R4", rst_req_o, 0, "after restart");
    idle(15); chk("R4", rst_req_o, 0, "15 after restart");
    idle(1); chk("R4", rst_req_o, 1, "16 after restart");

    // R4 restart on the time-out edge wins
    do_reset();
    wr(4'h1, 8'h00); wr(4'h0, 8'h02); idle(7); wr(4'h8, 8'hA5);
    chk("R4", rst_req_o, 0, "restart beats timeout");
    idle(7); chk("R4", rst_req_o, 0, "7 after");
    idle(1); chk("R4", rst_req_o, 1, "8 after");

    // R6 window
    do_reset();
    wr(4'h1, 8'h01); wr(4'h0, 8'h06); idle(4); wr(4'h8, 8'hA5);
    chk("R6", rst_req_o, 1, "early clear");
    do_reset();
    wr(4'h1, 8'h01); wr(4'h0, 8'h06); idle(7); wr(4'h8, 8'hA5);
    chk("R6", rst_req_o, 1, "clear on closing edge");
    do_reset();
    wr(4'h1, 8'h01); wr(4'h0, 8'h06); idle(8); wr(4'h8, 8'hA5);
    chk("R6", rst_req_o, 0, "first open clear");
    idle(23); chk("R6", rst_req_o, 0, "window+period-1");
    idle(1); chk("R6", rst_req_o, 1, "window+period");

    // R7 R8 early warning and interrupt enable
    do_reset();
    wr(4'h1, 8'h02); wr(4'h2, 8'h00); wr(4'h5, 8'h01); wr(4'h0, 8'h02);
    idle(7); chk("R7", irq_o, 0, "irq before offset");
    rd(4'h6, v); chk("R7", v, 8'h00, "flag before offset");
    idle(1); chk("R7", irq_o, 1, "irq at offset");
    rd(4'h6, v); chk("R7", v, 8'h01, "flag at offset");
    wr(4'h4, 8'h01); chk("R8", irq_o, 0, "irq masked");
    rd(4'h5, v); chk("R8", v, 8'h00, "ien via set offset");
    rd(4'h6, v); chk("R8", v, 8'h01, "flag kept");
    wr(4'h6, 8'h01); rd(4'h6, v); chk("R7", v, 8'h00, "flag cleared");
    wr(4'h5, 8'h01); rd(4'h4, v); chk("R8", v, 8'h01, "ien via clr offset");
    chk("R8", irq_o, 0, "no flag no irq");

    // R9 always-on
    do_reset();
    wr(4'h1, 8'h00); wr(4'h0, 8'h80);
    rd(4'h0, v); chk("R9", v, 8'h80, "aon set");
    wr(4'h0, 8'h00); rd(4'h0, v); chk("R9", v, 8'h80, "ctrl locked");
    wr(4'h1, 8'h33); rd(4'h1, v); chk("R9", v, 8'h00, "cfg locked");
    idle(5); chk("R9", rst_req_o, 0, "aon counting 7");
    idle(1); chk("R9", rst_req_o, 1, "aon timeout 8");

    // R10 busy flag
    do_reset();
    wr(4'h0, 8'h00); rd(4'h7, v); chk("R10", v, 8'h80, "busy 1st");
    idle(1); rd(4'h7, v); chk("R10", v, 8'h80, "busy 2nd");
    idle(1); rd(4'h7, v); chk("R10", v, 8'h00, "busy done");
    wr(4'h2, 8'h03); rd(4'h7, v); chk("R10", v, 8'h00, "ewc no busy");

    // R3 clamp of codes above 0xB, full ceiling
    do_reset();
    wr(4'h1, 8'hFF); rd(4'h1, v); chk("R3", v, 8'hFF, "raw cfg");
    wr(4'h0, 8'h02);
    idle(16383); chk("R3", rst_req_o, 0, "clamp 16383");
    idle(1); chk("R3", rst_req_o, 1, "clamp 16384");

    // random trials: R4 R5 R6 R7
    for (int t = 0; t < 40; t++) begin
      int pc, wc, ec, wen, bad, wv, p, e, d;
      logic exp_rst, exp_flag;
      string tag;
      pc = $urandom % 4; wc = $urandom % 4; ec = $urandom % 4;
      wen = $urandom % 2; bad = ($urandom % 5 == 0) ? 1 : 0;
      p = span(pc); e = span(ec); wv = wen ? span(wc) : 0;
      d = 1 + ($urandom % (wv + p + 8));
      do_reset();
      wr(4'h1, 8'((wc << 4) | pc)); wr(4'h2, 8'(ec)); wr(4'h5, 8'h01);
      wr(4'h0, wen ? 8'h06 : 8'h02);
      idle(d - 1);
      wr(4'h8, bad ? 8'h3C : 8'hA5);
      exp_rst = (d > wv + p) || bad || (wen && d <= wv);
      exp_flag = (e <= p) && (bad ? (wv + e <= d) : (wv + e < d));
      tag = bad ? "R5" : (wen ? "R6" : "R4");
      chk(tag, rst_req_o, exp_rst, "random clear outcome");
      chk("R7", irq_o, exp_flag, "random early warning");
      if (!exp_rst) begin
        idle(wv + p - 1); chk(tag, rst_req_o, 0, "random next period -1");
        idle(1); chk(tag, rst_req_o, 1, "random next period");
      end
    end

    summary();
  end

endmodule